// File: doc/BRIEF.md
# Integer Execute Unit with Overflow Trap

This block is the integer execute stage for register-to-register arithmetic and bitwise operations. It is purely combinational. Two operands and a 6-bit function code go in. The result comes out together with a destination write enable, a trap request and status flags, all in the same cycle.

Addition and subtraction each come in two forms. The trapping form raises a trap on signed overflow and withholds the destination write. The wrapping form produces the same bit pattern and always allows the write. The status flags are kept apart from each other:

- The unsigned carry (or, on subtraction, the borrow) has its own output.
- Signed overflow has its own output.

A function code outside the supported set yields a zero result, no write, and an illegal-operation indication.

Being combinational, the unit has no handshake. Inputs are expected to be stable while the surrounding pipeline samples the outputs.

Top module: `alu_exec`

## Requirements
- R1: Codes 0x20 (trapping) and 0x21 (wrapping) drive `res` with `opa + opb` modulo 2^W.
- R2: Codes 0x22 (trapping) and 0x23 (wrapping) drive `res` with `opa - opb` modulo 2^W.
- R3: For codes 0x20 and 0x22, signed overflow sets `trap` to 1 and `wr_en` to 0. Without signed overflow, `trap` is 0 and `wr_en` is 1.
- R4: For codes 0x21 and 0x23, `trap` is always 0 and `wr_en` is always 1. `res` equals what the matching trapping code gives for the same operands.
- R5: On additions (0x20, 0x21), `cy` is the unsigned carry out of bit W-1.
- R6: On subtractions (0x22, 0x23), `cy` is the borrow, which is 1 exactly when `opa < opb` as unsigned numbers.
- R7: On additions and subtractions, `sovf` is 1 exactly when the true two's-complement result does not fit in W bits. This holds for both the trapping and the wrapping forms.
- R8: Codes 0x24, 0x25, 0x26 and 0x27 drive `res` with AND, OR, XOR and NOR of the operands, in that order.
- R9: For the bitwise codes, `cy`, `sovf`, `trap` and `bad_fn` are 0 and `wr_en` is 1.
- R10: Any other code gives `res` = 0, `wr_en` = 0, `bad_fn` = 1, and `cy`, `sovf` and `trap` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | W (32) | First source operand |
| opb | input | W (32) | Second source operand |
| fn | input | 6 | Function code |
| res | output | W (32) | Operation result |
| wr_en | output | 1 | Destination write allowed |
| trap | output | 1 | Overflow trap request |
| cy | output | 1 | Carry (add) or borrow (subtract) |
| sovf | output | 1 | Signed overflow status |
| bad_fn | output | 1 | Unsupported function code |

## Verification
The hardest condition to reach is a trapping subtraction that overflows only because the second operand's sign flips: for example, the most negative value minus one, or zero minus the most negative value. Uniformly random operands land on these boundaries rarely. The stimulus therefore draws its operands from a pool of sign-boundary values (0, 1, all ones, the extreme signed values and their neighbours) mixed with random words. It also sweeps every code of the 6-bit function space, so the illegal-code path is covered on every value.

// File: rtl/alu_exec_pkg.sv
package alu_exec_pkg;

  localparam int unsigned FN_W = 6;

  typedef enum logic [FN_W-1:0] {
    FN_ADD_TRAP = 6'h20,
    FN_ADD_WRAP = 6'h21,
    FN_SUB_TRAP = 6'h22,
    FN_SUB_WRAP = 6'h23,
    FN_AND      = 6'h24,
    FN_OR       = 6'h25,
    FN_XOR      = 6'h26,
    FN_NOR      = 6'h27
  } fn_code_e;

  typedef enum logic [1:0] {
    BW_AND = 2'd0,
    BW_OR  = 2'd1,
    BW_XOR = 2'd2,
    BW_NOR = 2'd3
  } bw_sel_e;

  typedef struct packed {
    logic    known;
    logic    arith;
    logic    subtract;
    logic    may_trap;
    bw_sel_e bw;
  } op_ctl_t;

endpackage

// File: rtl/alu_fn_decode.sv
module alu_fn_decode
  import alu_exec_pkg::*;
(
  input  logic [FN_W-1:0] fn,
  output op_ctl_t         ctl
);
  always_comb begin
    ctl = '{known: 1'b0, arith: 1'b0, subtract: 1'b0, may_trap: 1'b0, bw: BW_AND};
    case (fn)
      FN_ADD_TRAP: begin ctl.known = 1'b1; ctl.arith = 1'b1; ctl.may_trap = 1'b1; end
      FN_ADD_WRAP: begin ctl.known = 1'b1; ctl.arith = 1'b1; end
      FN_SUB_TRAP: begin ctl.known = 1'b1; ctl.arith = 1'b1; ctl.subtract = 1'b1; ctl.may_trap = 1'b1; end
      FN_SUB_WRAP: begin ctl.known = 1'b1; ctl.arith = 1'b1; ctl.subtract = 1'b1; end
      FN_AND:      begin ctl.known = 1'b1; ctl.bw = BW_AND; end
      FN_OR:       begin ctl.known = 1'b1; ctl.bw = BW_OR;  end
      FN_XOR:      begin ctl.known = 1'b1; ctl.bw = BW_XOR; end
      FN_NOR:      begin ctl.known = 1'b1; ctl.bw = BW_NOR; end
      default:     ;
    endcase
  end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cy_or_borrow,
  output logic         sovf
);
  localparam int unsigned MSB = W - 1;

  logic [W-1:0] b_eff;
  logic [W:0]   wide;

  always_comb begin
    b_eff        = sub ? ~b : b;
    wide         = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
    sum          = wide[W-1:0];
    // the adder carry-out is inverted to form a borrow on subtraction
    cy_or_borrow = sub ? ~wide[W] : wide[W];
    sovf         = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
  end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
  import alu_exec_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  bw_sel_e      sel,
  output logic [W-1:0] y
);
  for (genvar i = 0; i < W; i++) begin : g_lane
    always_comb begin
      case (sel)
        BW_AND:  y[i] = a[i] & b[i];
        BW_OR:   y[i] = a[i] | b[i];
        BW_XOR:  y[i] = a[i] ^ b[i];
        default: y[i] = ~(a[i] | b[i]);
      endcase
    end
  end
endmodule

// File: rtl/alu_exec.sv
module alu_exec
  import alu_exec_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]    opa,
  input  logic [W-1:0]    opb,
  input  logic [FN_W-1:0] fn,
  output logic [W-1:0]    res,
  output logic            wr_en,
  output logic            trap,
  output logic            cy,
  output logic            sovf,
  output logic            bad_fn
);
  op_ctl_t      ctl;
  logic [W-1:0] as_sum;
  logic         as_cy;
  logic         as_ovf;
  logic [W-1:0] bw_y;

  alu_fn_decode u_dec (.fn(fn), .ctl(ctl));

  alu_addsub #(.W(W)) u_as (
    .a(opa), .b(opb), .sub(ctl.subtract),
    .sum(as_sum), .cy_or_borrow(as_cy), .sovf(as_ovf)
  );

  alu_bitwise #(.W(W)) u_bw (.a(opa), .b(opb), .sel(ctl.bw), .y(bw_y));

  always_comb begin
    bad_fn = ~ctl.known;
    if (!ctl.known) begin
      res = '0; cy = 1'b0; sovf = 1'b0; trap = 1'b0; wr_en = 1'b0;
    end else if (ctl.arith) begin
      res   = as_sum;
      cy    = as_cy;
      sovf  = as_ovf;
      trap  = ctl.may_trap & as_ovf;
      wr_en = ~(ctl.may_trap & as_ovf);
    end else begin
      res = bw_y; cy = 1'b0; sovf = 1'b0; trap = 1'b0; wr_en = 1'b1;
    end
  end
endmodule

// File: rtl/alu_exec_chk.sv
module alu_exec_chk #(
  parameter int unsigned W = 32
) (
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic [5:0]   fn,
  input logic [W-1:0] res,
  input logic         wr_en,
  input logic         trap,
  input logic         cy,
  input logic         sovf,
  input logic         bad_fn
);
  always_comb begin
    if (!$isunknown({opa, opb, fn})) begin
      a_r3_trap_blocks_write: assert (!(trap && wr_en));
      a_r3_trap_needs_ovf: assert (!trap || sovf);
      a_r4_wrap_never_traps: assert (!(fn == 6'h21 || fn == 6'h23) || (!trap && wr_en));
      a_r6_borrow_is_less: assert (!(fn == 6'h22 || fn == 6'h23) || (cy == (opa < opb)));
      a_r9_bitwise_quiet: assert (!(fn >= 6'h24 && fn <= 6'h27) || (!cy && !sovf && !trap && wr_en && !bad_fn));
      a_r10_illegal_zero: assert (!bad_fn || (res == '0 && !wr_en && !trap && !cy && !sovf));
    end
  end
endmodule

bind alu_exec alu_exec_chk #(.W(W)) u_chk (
  .opa(opa), .opb(opb), .fn(fn), .res(res), .wr_en(wr_en),
  .trap(trap), .cy(cy), .sovf(sovf), .bad_fn(bad_fn)
);

// File: tb/alu_exec_bench.sv
`timescale 1ns/1ps
module alu_exec_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] opa, opb, res;
  logic [5:0]  fn;
  logic        wr_en, trap, cy, sovf, bad_fn;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  alu_exec u_alu_exec (
    .opa(opa), .opb(opb), .fn(fn), .res(res), .wr_en(wr_en),
    .trap(trap), .cy(cy), .sovf(sovf), .bad_fn(bad_fn)
  );

  // behavioural reference: expected {res, wr_en, trap, cy, sovf, bad_fn}
  function automatic logic [36:0] model(input logic [31:0] a, input logic [31:0] b, input logic [5:0] f);
    longint sa, sb, sr;
    logic [31:0] r;
    logic w, t, c, o, il;
    sa = longint'($signed(a)); sb = longint'($signed(b));
    r = '0; w = 1'b1; t = 1'b0; c = 1'b0; o = 1'b0; il = 1'b0;
    case (f)
      6'h20, 6'h21: begin
        r = a + b; c = (longint'(a) + longint'(b)) > 64'sd4294967295;
        sr = sa + sb; o = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
      end
      6'h22, 6'h23: begin
        r = a - b; c = a < b;
        sr = sa - sb; o = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
      end
      6'h24: r = a & b;
      6'h25: r = a | b;
      6'h26: r = a ^ b;
      6'h27: r = ~(a | b);
      default: begin w = 1'b0; il = 1'b1; end
    endcase
    if ((f == 6'h20 || f == 6'h22) && o) begin t = 1'b1; w = 1'b0; end
    return {r, w, t, c, o, il};
  endfunction

  task automatic check(input string tag, input logic [36:0] got, input logic [36:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s fn=%h a=%h b=%h actual res=%h w%0b t%0b c%0b o%0b i%0b expected res=%h w%0b t%0b c%0b o%0b i%0b",
               tag, fn, opa, opb, got[36:5], got[4], got[3], got[2], got[1], got[0],
               exp[36:5], exp[4], exp[3], exp[2], exp[1], exp[0]);
    end
  endtask

  // drive on the falling edge, compare just after the rising edge
  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [5:0] f, input string tag);
    @(negedge clk);
    opa = a; opb = b; fn = f;
    @(posedge clk);
    #1;
    check(tag, {res, wr_en, trap, cy, sovf, bad_fn}, model(a, b, f));
  endtask

  task automatic direct(input logic [31:0] a, input logic [31:0] b, input logic [5:0] f,
                        input logic [31:0] er, input logic [4:0] ef, input string tag);
    @(negedge clk);
    opa = a; opb = b; fn = f;
    @(posedge clk);
    #1;
    check(tag, {res, wr_en, trap, cy, sovf, bad_fn}, {er, ef});
  endtask

  function automatic logic [31:0] pick(input int unsigned k);
    case (k % 10)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'hFFFF_FFFF;
      3: return 32'h7FFF_FFFF;
      4: return 32'h8000_0000;
      5: return 32'h8000_0001;
      6: return 32'h7FFF_FFFE;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    opa = '0; opb = '0; fn = 6'h00;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R10 idle state: code 0 is unsupported
    direct(32'h1234_5678, 32'h9ABC_DEF0, 6'h00, 32'h0, 5'b00001, "R10 idle");
    // R1 R5 R7 carry/overflow separation
    direct(32'h8400E141, 32'hFF00F520, 6'h21, 32'h8301D661, 5'b10100, "R5 carry no ovf");
    direct(32'h2404B144, 32'h7F703502, 6'h21, 32'hA374E646, 5'b10010, "R7 ovf no carry");
    direct(32'h8404B144, 32'h9F703502, 6'h21, 32'h2374E646, 5'b10110, "R1 carry and ovf");
    // R3 trapping add suppresses write
    direct(32'h2404B144, 32'h7F703502, 6'h20, 32'hA374E646, 5'b01010, "R3 add trap");
    direct(32'h8400E141, 32'hFF00F520, 6'h20, 32'h8301D661, 5'b10100, "R3 add no trap");
    // R2 R6 subtract
    direct(32'd5, 32'd3, 6'h22, 32'd2, 5'b10000, "R2 sub");
    direct(32'd0, 32'd1, 6'h23, 32'hFFFF_FFFF, 5'b10100, "R6 borrow");
    direct(32'h8000_0000, 32'd1, 6'h22, 32'h7FFF_FFFF, 5'b01010, "R3 sub trap");
    direct(32'h8000_0000, 32'd1, 6'h23, 32'h7FFF_FFFF, 5'b10010, "R4 sub wrap");
    direct(32'd0, 32'h8000_0000, 6'h22, 32'h8000_0000, 5'b01110, "R7 zero minus min");
    // R8 R9 bitwise
    direct(32'habcd1234, 32'hffff0000, 6'h24, 32'habcd0000, 5'b10000, "R8 and");
    direct(32'habcd1234, 32'hffff0000, 6'h25, 32'hffff1234, 5'b10000, "R8 or");
    direct(32'habcd1234, 32'hffff0000, 6'h26, 32'h54321234, 5'b10000, "R8 xor");
    direct(32'habcd1234, 32'hffff0000, 6'h27, 32'h0000edcb, 5'b10000, "R9 nor");
    direct(32'hFFFF_FFFF, 32'hFFFF_FFFF, 6'h28, 32'h0, 5'b00001, "R10 code 0x28");
    // every code, boundary-biased operands; covers R1..R10 against the model
    for (int i = 0; i < 3000; i++) begin
      logic [5:0] f;
      f = (i % 3 == 0) ? 6'(i) : 6'(6'h20 + (i % 8));
      apply(pick($urandom), pick($urandom), f, "R1-R10 sweep R4");
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule